// File: doc/BRIEF.md
# Parallel Bit Deposit and Extract Unit

This block takes a 64-bit source word and a 64-bit mask, and scatters or gathers bits between them. In deposit mode, the lowest-order source bits are placed one after another into the positions where the mask holds a one. In extract mode, the source bits that sit under mask ones are collected and packed together at the low end of the result. Both modes walk the mask upward from bit 0 and keep a running destination or source index.

Operands enter on a valid/ready stream and results leave on a second valid/ready stream. The two register stages form a single pipeline that is stalled as a whole: while a result waits at the output and the consumer holds `out_ready` low, nothing inside moves and `in_ready` stays low. With no back-pressure, one operation is accepted on every cycle. The latency is always the same, whatever the operand values.

Top module: `pbx_unit`

## Requirements
- R1: While `rst_n` is low and in the cycle after it is released, `out_valid` is 0 and `in_ready` is 1.
- R2: In deposit mode, j starts at 0. Mask bit positions i are scanned from 0 upward. At each i where the mask is 1, result bit i is set to source bit j, and then j is incremented.
- R3: In extract mode, j starts at 0. Mask bit positions i are scanned from 0 upward. At each i where the mask is 1, result bit j is set to source bit i, and then j is incremented.
- R4: Every result bit that the R2/R3 rules do not write is 0. This covers deposit positions where the mask is 0, and extract positions at or above the mask's popcount.
- R5: In deposit mode, source bits at positions at or above the popcount of the mask have no effect on the result.
- R6: `in_mode` = 0 selects deposit, and `in_mode` = 1 selects extract.
- R7: Suppose an operation is accepted in cycle t (`in_valid` and `in_ready` both high) and `out_ready` stays high. Then its result appears with `out_valid` high in cycle t+2, for any operand values.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` hold their values into the next cycle.
- R9: `in_ready` equals `!out_valid || out_ready`. An input offered while `in_ready` is 0 is not taken.
- R10: A zero mask gives a zero result in both modes. An all-ones mask returns the source unchanged in both modes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand word, mask and mode are valid |
| in_ready | output | 1 | Unit can accept operands this cycle |
| in_src | input | 64 | Source word |
| in_msk | input | 64 | Mask word |
| in_mode | input | 1 | 0 = deposit, 1 = extract |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 64 | Result word |

## Verification
A wrong running index shows up as a shifted or scrambled `out_data` exactly two cycles after the operands are accepted. Such errors usually affect only the higher mask positions, so the tests use sparse masks, dense masks and masks with a single end bit. A broken stall or valid bit shows up as a cycle mismatch on `out_valid` or `in_ready` at the very next edge. A reference pipeline in the testbench is compared against the outputs on every clock, so timing errors are caught on the cycle they occur.

// File: rtl/pbx_pkg.sv
package pbx_pkg;
  localparam int unsigned PBX_W = 64;

  typedef enum logic {
    PBX_DEPOSIT = 1'b0,
    PBX_EXTRACT = 1'b1
  } pbx_mode_e;
endpackage

// File: rtl/pbx_rank.sv
// Running index: for each bit position, the number of mask ones strictly below it.
module pbx_rank #(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]         msk,
  output logic [W-1:0][CW-1:0] rank,
  output logic [CW-1:0]        total
);
  logic [CW-1:0] acc;

  always_comb begin
    acc = '0;
    for (int i = 0; i < W; i++) begin
      rank[i] = acc;
      acc     = acc + CW'(msk[i]);
    end
    total = acc;
  end
endmodule

// File: rtl/pbx_route.sv
// Shared datapath: selects deposit scatter or extract gather using one rank vector.
module pbx_route
  import pbx_pkg::*;
#(
  parameter int unsigned W  = 64,
  parameter int unsigned CW = $clog2(W) + 1
) (
  input  logic [W-1:0]         src,
  input  logic [W-1:0]         msk,
  input  logic [W-1:0][CW-1:0] rank,
  input  pbx_mode_e            mode,
  output logic [W-1:0]         res
);
  localparam int unsigned LW = $clog2(W);

  logic [W-1:0] dep;
  logic [W-1:0] ext;

  // Deposit: every mask-set lane pulls the source bit named by its rank.
  for (genvar g = 0; g < W; g++) begin : g_dep
    assign dep[g] = msk[g] & src[rank[g][LW-1:0]];
  end

  // Extract: every mask-set source bit is pushed down to its rank.
  always_comb begin
    ext = '0;
    for (int i = 0; i < W; i++) begin
      ext = ext | (W'(msk[i] & src[i]) << rank[i]);
    end
  end

  assign res = (mode == PBX_EXTRACT) ? ext : dep;
endmodule

// File: rtl/pbx_unit.sv
module pbx_unit
  import pbx_pkg::*;
#(
  parameter int unsigned W = PBX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_msk,
  input  logic         in_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned CW = $clog2(W) + 1;

  // Whole pipeline advances together unless a result is waiting.
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // Stage A: operands plus precomputed rank vector.
  logic                  a_vld;
  logic [W-1:0]          a_src;
  logic [W-1:0]          a_msk;
  pbx_mode_e             a_mode;
  logic [W-1:0][CW-1:0]  a_rank;

  logic [W-1:0][CW-1:0]  rank_c;
  logic [CW-1:0]         total_c;
  logic [W-1:0]          route_res;

  pbx_rank #(.W(W), .CW(CW)) u_rank (
    .msk   (in_msk),
    .rank  (rank_c),
    .total (total_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_vld  <= 1'b0;
      a_src  <= '0;
      a_msk  <= '0;
      a_mode <= PBX_DEPOSIT;
      a_rank <= '0;
    end else if (adv) begin
      a_vld <= in_valid;
      if (in_valid) begin
        a_src  <= in_src;
        a_msk  <= in_msk;
        a_mode <= pbx_mode_e'(in_mode);
        a_rank <= rank_c;
      end
    end
  end

  pbx_route #(.W(W), .CW(CW)) u_route (
    .src  (a_src),
    .msk  (a_msk),
    .rank (a_rank),
    .mode (a_mode),
    .res  (route_res)
  );

  // Stage B: result register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (adv) begin
      out_valid <= a_vld;
      if (a_vld) out_data <= route_res;
    end
  end

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> a_vld);

  // R7
  advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && in_ready) |=> out_valid);

  // R4
  dep_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (a_vld && a_mode == PBX_DEPOSIT) |-> ((route_res & ~a_msk) == '0));

  // R4
  ones_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    a_vld |-> ($countones(route_res) <= $countones(a_msk)));

  // R4
  rank_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (int'(total_c) == $countones(in_msk)));
endmodule

// File: tb/sim_pbx_unit.sv
`timescale 1ns/1ps
module sim_pbx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, in_ready, in_mode;
  logic [63:0] in_src, in_msk;
  logic        out_valid, out_ready;
  logic [63:0] out_data;

  int n_chk  = 0;
  int n_err  = 0;

  always #4 clk = ~clk;

  pbx_unit u0 (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_msk(in_msk), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [63:0] ref_dep(input logic [63:0] s, input logic [63:0] m);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i]) begin
        r[i] = s[j];
        j++;
      end
    end
    return r;
  endfunction

  function automatic logic [63:0] ref_ext(input logic [63:0] s, input logic [63:0] m);
    logic [63:0] r = '0;
    int j = 0;
    for (int i = 0; i < 64; i++) begin
      if (m[i]) begin
        r[j] = s[i];
        j++;
      end
    end
    return r;
  endfunction

  // Reference pipeline state.
  logic        ma_v = 0, mo_v = 0, ma_md = 0, mo_md = 0;
  logic [63:0] ma_d = '0, mo_d = '0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one cycle of stimulus at the falling edge, then check the outputs after the next rising edge.
  task automatic step(input logic v, input logic [63:0] s, input logic [63:0] m,
                      input logic md, input logic rdy);
    logic stall;
    in_valid = v; in_src = s; in_msk = m; in_mode = md; out_ready = rdy;
    #1;
    stall = mo_v && !rdy;
    chk(in_ready === !stall, "R9", 64'(in_ready), 64'(!stall));
    @(posedge clk);
    if (!stall) begin
      mo_v = ma_v; mo_d = ma_d; mo_md = ma_md;
      ma_v = v; ma_md = md;
      ma_d = md ? ref_ext(s, m) : ref_dep(s, m);
    end
    @(negedge clk);
    chk(out_valid === mo_v, "R7", 64'(out_valid), 64'(mo_v));
    if (mo_v)
      chk(out_data === mo_d, stall ? "R8" : (mo_md ? "R3" : "R2"), out_data, mo_d);
  endtask

  task automatic one(input logic [63:0] s, input logic [63:0] m, input logic md,
                     input logic [63:0] exp, input string tag);
    step(1'b1, s, m, md, 1'b1);
    chk(out_valid === 1'b0, "R7", 64'(out_valid), 64'd0);
    step(1'b0, '0, '0, 1'b0, 1'b1);
    chk(out_valid === 1'b1 && out_data === exp, tag, out_data, exp);
    step(1'b0, '0, '0, 1'b0, 1'b1);
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; in_src = '0; in_msk = '0; in_mode = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);
    chk(in_ready === 1'b1, "R1", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", 64'(out_valid), 64'd0);

    one(64'h5, 64'hF0, 1'b0, 64'h50, "R2");
    one(64'hA0, 64'hF0, 1'b1, 64'hA, "R3");
    one(64'hFFFF_FFFF_FFFF_FFF5, 64'hF0, 1'b0, 64'h50, "R5");
    one(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0001, 1'b1, 64'h3, "R4");
    one(64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0F00, 1'b0, 64'h0F00, "R4");
    one(64'h3, 64'hC, 1'b0, 64'hC, "R6");
    one(64'h3, 64'hC, 1'b1, 64'h0, "R6");
    one(64'hDEAD_BEEF_0123_4567, 64'h0, 1'b0, 64'h0, "R10");
    one(64'hDEAD_BEEF_0123_4567, 64'h0, 1'b1, 64'h0, "R10");
    one(64'hDEAD_BEEF_0123_4567, '1, 1'b0, 64'hDEAD_BEEF_0123_4567, "R10");
    one(64'hDEAD_BEEF_0123_4567, '1, 1'b1, 64'hDEAD_BEEF_0123_4567, "R10");

    // Back-to-back then a long stall (R8, R9).
    step(1'b1, 64'h1234, 64'hFF00, 1'b0, 1'b1);
    step(1'b1, 64'hFF00, 64'hFF00, 1'b1, 1'b1);
    step(1'b1, 64'h7, 64'h1_0001, 1'b0, 1'b0);
    step(1'b1, 64'h9, 64'h3, 1'b1, 1'b0);
    step(1'b1, 64'h9, 64'h3, 1'b1, 1'b0);
    step(1'b0, '0, '0, 1'b0, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b1);
    step(1'b0, '0, '0, 1'b0, 1'b1);

    // Mixed random stream with random back-pressure and varied mask density.
    for (int k = 0; k < 3000; k++) begin
      logic [63:0] s, m;
      s = {$urandom, $urandom};
      m = {$urandom, $urandom};
      case (k % 4)
        1: m = m & {$urandom, $urandom};
        2: m = m | {$urandom, $urandom};
        3: m = 64'(1) << (k % 64);
        default: ;
      endcase
      step(($urandom % 4) != 0, s, m, $urandom % 2, ($urandom % 3) != 0);
    end
    repeat (4) step(1'b0, '0, '0, 1'b0, 1'b1);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule